// File: doc/BRIEF.md
# Synchronous Serial Port with Internal Loopback

This block is a synchronous serial master. Software writes words into a 16-entry transmit FIFO through a small write port. An idle shift engine takes each word and sends it MSB-first on the data-out pin, framed by an active-low select. It fills a receive word at the same time and places that word in a 16-entry receive FIFO, which software drains with a pop strobe. Frames can be 4 to 16 bits long. The resting level of the serial clock can be chosen.

There are two frame styles. The full-duplex style shifts data out and in during the same bit times. The half-duplex style first sends the word, then clocks in a reply of equal length. A loopback control routes the transmit shifter output straight into the receive shifter, and the pins keep toggling while it does. Loopback acts in the full-duplex style only. Two service-request flags compare the FIFO fill levels with programmable thresholds. Each flag has an enable that gates only its interrupt output. A sticky error flag records any ignored FIFO access.

Top module: `ssp_top`

## Requirements
- R1: When no frame is active, `sclk` rests at the level of control bit 3 (0 = low, 1 = high), and `cs_n` is high.
- R2: Control bits [11:8] hold the frame length minus one; a value below 3 gives 4 bits. Each frame holds `cs_n` low and sends bits MSB-first. Data is launched on the edge where `sclk` returns to its resting level and is captured on the edge where it leaves that level.
- R3: With control bit 2 (loopback) set and control bit 4 clear, the received word equals the transmitted word, and `miso` has no effect.
- R4: While loopback is active, the transmitted bits still appear on `mosi` with normal timing.
- R5: With control bit 4 set (half-duplex style), a frame sends N bits and then captures N bits from `miso`. The received word is the data on `miso`, and loopback has no effect.
- R6: `rx_req` is 1 exactly when the receive fill level is at least control bits [19:16] plus one. `tx_req` is 1 exactly when the transmit fill level is at most control bits [27:24].
- R7: `rx_irq` equals `rx_req` gated by control bit 0, and `tx_irq` equals `tx_req` gated by control bit 1. Changing an enable never changes a request flag.
- R8: After reset the control register is all zero: `sclk` low, `cs_n` high, `tx_req` 1, `rx_req` 0, both interrupts 0 and `err` 0.
- R9: Each FIFO holds 16 words. A push to a full FIFO and a pop from an empty FIFO are dropped. `err` then goes to 1 and stays there until reset.
- R10: A write with `wr_addr` 0 loads the control register. A write with `wr_addr` 1 pushes `wr_data[15:0]` into the transmit FIFO. `rd_pop` removes the oldest receive word, and that word is shown on `rd_data`.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 2 | Write target: 0 control, 1 transmit data |
| wr_data | input | 32 | Write data |
| rd_pop | input | 1 | Remove the oldest receive word |
| rd_data | output | 16 | Oldest receive word |
| sclk | output | 1 | Serial clock |
| cs_n | output | 1 | Active-low frame select |
| mosi | output | 1 | Serial data out |
| miso | input | 1 | Serial data in |
| tx_req | output | 1 | Transmit service request flag |
| rx_req | output | 1 | Receive service request flag |
| tx_irq | output | 1 | Masked transmit interrupt |
| rx_irq | output | 1 | Masked receive interrupt |
| err | output | 1 | Sticky ignored-access flag |

## Verification
A wrong bit counter or an alignment error in the shifter shows up as a wrong or shifted word on `mosi` when `cs_n` next rises. The matching received word is wrong on `rd_data` at the first pop after that frame. A loopback select that ignores the frame style is caught in the first half-duplex or external frame, because the received word then follows the wrong source. A bad FIFO level shows on `tx_req` or `rx_req` in the cycle after the offending push or pop. A drop that fails to happen leaves a leftover receive word, which keeps `rx_req` high after the expected drain.

// File: rtl/ssp_pkg.sv
package ssp_pkg;

    localparam int CTRL_W = 32;
    localparam int LEN_W  = 4;
    localparam int THR_W  = 4;
    localparam int MIN_BITS = 4;

    localparam logic [1:0] ADDR_CTRL = 2'd0;
    localparam logic [1:0] ADDR_TXD  = 2'd1;

    // control register layout, LSB last
    typedef struct packed {
        logic [3:0]       rsv3;
        logic [THR_W-1:0] tx_thr;
        logic [3:0]       rsv2;
        logic [THR_W-1:0] rx_thr;
        logic [3:0]       rsv1;
        logic [LEN_W-1:0] len_m1;
        logic [2:0]       rsv0;
        logic             half_dup;
        logic             cpol;
        logic             loopback;
        logic             tx_ie;
        logic             rx_ie;
    } ctrl_t;

    typedef enum logic [1:0] {
        SH_IDLE = 2'd0,
        SH_XFER = 2'd1,
        SH_RECV = 2'd2
    } sh_state_e;

    function automatic logic [LEN_W:0] frame_bits(input logic [LEN_W-1:0] m1);
        if (m1 < LEN_W'(MIN_BITS - 1))
            return (LEN_W+1)'(MIN_BITS);
        return {1'b0, m1} + (LEN_W+1)'(1);
    endfunction

endpackage

// File: rtl/ssp_fifo.sv
module ssp_fifo #(
    parameter int W = 16,
    parameter int DEPTH = 16,
    localparam int LW = $clog2(DEPTH + 1)
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          push,
    input  logic [W-1:0]  din,
    input  logic          pop,
    output logic [W-1:0]  dout,
    output logic [LW-1:0] level,
    output logic          fault
);
    localparam int PW = (DEPTH > 1) ? $clog2(DEPTH) : 1;

    logic [W-1:0]  mem [DEPTH];
    logic [PW-1:0] wr_ptr, rd_ptr;
    logic          full, empty, push_ok, pop_ok;

    function automatic logic [PW-1:0] bump(input logic [PW-1:0] p);
        return (p == PW'(DEPTH - 1)) ? '0 : p + PW'(1);
    endfunction

    assign full    = (level == LW'(DEPTH));
    assign empty   = (level == '0);
    assign push_ok = push && !full;
    assign pop_ok  = pop && !empty;
    assign fault   = (push && full) || (pop && empty);
    assign dout    = mem[rd_ptr];

    always_ff @(posedge clk) begin
        if (push_ok)
            mem[wr_ptr] <= din;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            wr_ptr <= '0;
            rd_ptr <= '0;
            level  <= '0;
        end else begin
            if (push_ok) wr_ptr <= bump(wr_ptr);
            if (pop_ok)  rd_ptr <= bump(rd_ptr);
            case ({push_ok, pop_ok})
                2'b10:   level <= level + LW'(1);
                2'b01:   level <= level - LW'(1);
                default: level <= level;
            endcase
        end
    end
endmodule

// File: rtl/ssp_shifter.sv
module ssp_shifter
    import ssp_pkg::*;
#(
    parameter int W = 16,
    parameter int HALF_DIV = 2,
    localparam int BW = $clog2(W + 1)
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          cpol,
    input  logic          loopback,
    input  logic          half_dup,
    input  logic [BW-1:0] nbits,
    input  logic          tx_ready,
    input  logic [W-1:0]  tx_word,
    output logic          tx_take,
    input  logic          miso,
    output logic          rx_push,
    output logic [W-1:0]  rx_word,
    output logic          sclk,
    output logic          cs_n,
    output logic          mosi
);
    localparam int CW = (HALF_DIV > 1) ? $clog2(HALF_DIV) : 1;

    sh_state_e     state;
    logic [CW-1:0] div_cnt;
    logic          act;
    logic [BW-1:0] bit_left;
    logic [W-1:0]  sh_tx, sh_rx, mask;
    logic          cs_q, tick, capture, rx_bit;

    assign tick    = (div_cnt == CW'(HALF_DIV - 1));
    assign capture = (state == SH_RECV) || (state == SH_XFER && !half_dup);
    // internal route only in the full-duplex style
    assign rx_bit  = (loopback && !half_dup) ? sh_tx[W-1] : miso;
    assign tx_take = (state == SH_IDLE) && tx_ready;
    assign mask    = (W'(1) << nbits) - W'(1);
    assign rx_word = sh_rx & mask;
    assign sclk    = cpol ^ act;
    assign cs_n    = cs_q;
    assign mosi    = sh_tx[W-1];

    always_ff @(posedge clk) begin
        if (rst) begin
            state    <= SH_IDLE;
            div_cnt  <= '0;
            act      <= 1'b0;
            bit_left <= '0;
            sh_tx    <= '0;
            sh_rx    <= '0;
            cs_q     <= 1'b1;
            rx_push  <= 1'b0;
        end else begin
            rx_push <= 1'b0;
            if (state == SH_IDLE) begin
                if (tx_ready) begin
                    state    <= SH_XFER;
                    cs_q     <= 1'b0;
                    act      <= 1'b0;
                    div_cnt  <= '0;
                    bit_left <= nbits - BW'(1);
                    sh_tx    <= tx_word << (W - int'(nbits));
                    sh_rx    <= '0;
                end
            end else if (!tick) begin
                div_cnt <= div_cnt + CW'(1);
            end else begin
                div_cnt <= '0;
                if (!act) begin
                    act <= 1'b1;
                    if (capture)
                        sh_rx <= {sh_rx[W-2:0], rx_bit};
                end else begin
                    act <= 1'b0;
                    if (bit_left != '0) begin
                        bit_left <= bit_left - BW'(1);
                        sh_tx    <= sh_tx << 1;
                    end else if (state == SH_XFER && half_dup) begin
                        state    <= SH_RECV;
                        bit_left <= nbits - BW'(1);
                        sh_tx    <= '0;
                    end else begin
                        state   <= SH_IDLE;
                        cs_q    <= 1'b1;
                        rx_push <= 1'b1;
                    end
                end
            end
        end
    end
endmodule

// File: rtl/ssp_top.sv
module ssp_top
    import ssp_pkg::*;
#(
    parameter int DATA_W = 16,
    parameter int DEPTH = 16,
    parameter int HALF_DIV = 2
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              wr_en,
    input  logic [1:0]        wr_addr,
    input  logic [31:0]       wr_data,
    input  logic              rd_pop,
    output logic [DATA_W-1:0] rd_data,
    output logic              sclk,
    output logic              cs_n,
    output logic              mosi,
    input  logic              miso,
    output logic              tx_req,
    output logic              rx_req,
    output logic              tx_irq,
    output logic              rx_irq,
    output logic              err
);
    localparam int LW = $clog2(DEPTH + 1);
    localparam int BW = $clog2(DATA_W + 1);

    ctrl_t             ctrl_q;
    logic [LW-1:0]     tx_level, rx_level;
    logic [DATA_W-1:0] tx_head, rx_word;
    logic              tx_take, rx_push, tx_fault, rx_fault, err_q;
    logic              unused_ctrl;

    assign unused_ctrl = ^{ctrl_q.rsv0, ctrl_q.rsv1, ctrl_q.rsv2, ctrl_q.rsv3};

    always_ff @(posedge clk) begin
        if (rst)
            ctrl_q <= '0;
        else if (wr_en && wr_addr == ADDR_CTRL)
            ctrl_q <= ctrl_t'(wr_data[CTRL_W-1:0]);
    end

    ssp_fifo #(.W(DATA_W), .DEPTH(DEPTH)) i_txf (
        .clk(clk), .rst(rst),
        .push(wr_en && wr_addr == ADDR_TXD), .din(wr_data[DATA_W-1:0]),
        .pop(tx_take), .dout(tx_head), .level(tx_level), .fault(tx_fault)
    );

    ssp_fifo #(.W(DATA_W), .DEPTH(DEPTH)) i_rxf (
        .clk(clk), .rst(rst),
        .push(rx_push), .din(rx_word),
        .pop(rd_pop), .dout(rd_data), .level(rx_level), .fault(rx_fault)
    );

    ssp_shifter #(.W(DATA_W), .HALF_DIV(HALF_DIV)) i_shift (
        .clk(clk), .rst(rst),
        .cpol(ctrl_q.cpol), .loopback(ctrl_q.loopback), .half_dup(ctrl_q.half_dup),
        .nbits(BW'(frame_bits(ctrl_q.len_m1))),
        .tx_ready(tx_level != '0), .tx_word(tx_head), .tx_take(tx_take),
        .miso(miso), .rx_push(rx_push), .rx_word(rx_word),
        .sclk(sclk), .cs_n(cs_n), .mosi(mosi)
    );

    // request flags follow the levels; enables mask only the interrupts
    assign tx_req = (tx_level <= LW'(ctrl_q.tx_thr));
    assign rx_req = (rx_level >= LW'(ctrl_q.rx_thr) + LW'(1));
    assign tx_irq = tx_req && ctrl_q.tx_ie;
    assign rx_irq = rx_req && ctrl_q.rx_ie;

    always_ff @(posedge clk) begin
        if (rst)
            err_q <= 1'b0;
        else if (tx_fault || rx_fault)
            err_q <= 1'b1;
    end
    assign err = err_q;
endmodule

// File: rtl/ssp_checks.sv
module ssp_checks #(
    parameter int DEPTH = 16,
    parameter int LW = 5
) (
    input logic          clk,
    input logic          rst,
    input logic          cs_n,
    input logic          sclk,
    input logic          mosi,
    input logic          cpol,
    input logic          tx_ie,
    input logic          rx_ie,
    input logic          tx_irq,
    input logic          rx_irq,
    input logic          err,
    input logic [LW-1:0] tx_level,
    input logic [LW-1:0] rx_level
);
    a_r1_idle_clock: assert property (@(posedge clk) disable iff (rst)
        cs_n |-> (sclk == cpol));

    a_r2_launch_edge: assert property (@(posedge clk) disable iff (rst)
        (!cs_n && !$past(cs_n) && $stable(cpol) && (mosi != $past(mosi)))
        |-> (sclk == cpol && $past(sclk) != cpol));

    a_r7_tx_masked: assert property (@(posedge clk) disable iff (rst)
        !tx_ie |-> !tx_irq);

    a_r7_rx_masked: assert property (@(posedge clk) disable iff (rst)
        !rx_ie |-> !rx_irq);

    a_r9_err_sticky: assert property (@(posedge clk) disable iff (rst)
        err |=> err);

    a_r9_no_overflow: assert property (@(posedge clk) disable iff (rst)
        (tx_level <= LW'(DEPTH)) && (rx_level <= LW'(DEPTH)));
endmodule

bind ssp_top ssp_checks #(.DEPTH(DEPTH), .LW(LW)) i_checks (
    .clk(clk), .rst(rst), .cs_n(cs_n), .sclk(sclk), .mosi(mosi),
    .cpol(ctrl_q.cpol), .tx_ie(ctrl_q.tx_ie), .rx_ie(ctrl_q.rx_ie),
    .tx_irq(tx_irq), .rx_irq(rx_irq), .err(err),
    .tx_level(tx_level), .rx_level(rx_level)
);

// File: tb/test_ssp_top.sv
module test_ssp_top;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        wr_en = 1'b0;
    logic [1:0]  wr_addr = '0;
    logic [31:0] wr_data = '0;
    logic        rd_pop = 1'b0;
    logic        miso = 1'b0;
    logic [15:0] rd_data;
    logic        sclk, cs_n, mosi, tx_req, rx_req, tx_irq, rx_irq, err;

    ssp_top i_ssp_top (
        .clk(clk), .rst(rst), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
        .rd_pop(rd_pop), .rd_data(rd_data), .sclk(sclk), .cs_n(cs_n), .mosi(mosi),
        .miso(miso), .tx_req(tx_req), .rx_req(rx_req), .tx_irq(tx_irq),
        .rx_irq(rx_irq), .err(err)
    );

    always #10 clk = ~clk;

    int checks = 0;
    int errors = 0;

    // frame settings the monitor works from
    int          cur_len = 4;
    logic        cur_mw = 1'b0;
    logic        cur_cpol = 1'b0;
    logic [15:0] slave_word = '0;
    logic [31:0] ctrl_val = '0;

    logic [15:0] exp_q[$];
    int          frames_seen = 0;
    logic [15:0] mon_acc;
    int          mon_k;
    logic [31:0] slave_sr;

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    function automatic logic [15:0] lmask(input int n);
        return 16'((32'd1 << n) - 1);
    endfunction

    // bench slave: loads its reply when the frame opens, shifts on trailing edges
    always @(negedge cs_n) begin
        mon_acc = '0;
        mon_k = 0;
        if (cur_mw)
            slave_sr = {16'b0, slave_word & lmask(cur_len)} << (32 - 2 * cur_len);
        else
            slave_sr = {16'b0, slave_word & lmask(cur_len)} << (32 - cur_len);
        miso = slave_sr[31];
    end

    always @(sclk) begin
        if (cs_n === 1'b0) begin
            if (sclk !== cur_cpol) begin
                if (mon_k < cur_len) mon_acc = {mon_acc[14:0], mosi};
                mon_k++;
            end else begin
                slave_sr = slave_sr << 1;
                miso = slave_sr[31];
            end
        end
    end

    // scoreboard monitor: each closed frame is compared with the oldest expected word
    always @(posedge cs_n) begin
        if (!rst) begin
            logic [15:0] e;
            int edges;
            frames_seen++;
            checks++;
            edges = cur_mw ? 2 * cur_len : cur_len;
            if (exp_q.size() == 0) begin
                errors++;
                $display("FAIL R2 unexpected frame: actual %h expected none", mon_acc);
            end else begin
                e = exp_q.pop_front();
                if (mon_acc !== e || mon_k != edges) begin
                    errors++;
                    $display("FAIL R2/R4 mosi frame: actual %h (%0d edges) expected %h (%0d edges)",
                             mon_acc, mon_k, e, edges);
                end
            end
        end
    end

    task automatic wr(input logic [1:0] a, input logic [31:0] d);
        @(negedge clk);
        wr_en = 1'b1; wr_addr = a; wr_data = d;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic set_ctrl(input logic [31:0] v);
        ctrl_val = v;
        cur_cpol = v[3];
        cur_mw = v[4];
        cur_len = (v[11:8] < 3) ? 4 : int'(v[11:8]) + 1;
        wr(2'd0, v);
    endtask

    task automatic send(input logic [15:0] w);
        exp_q.push_back(w & lmask(cur_len));
        wr(2'd1, {16'b0, w});
    endtask

    task automatic pop_check(input logic [15:0] exp, input string tag);
        @(negedge clk);
        check(tag, rd_data, exp);
        rd_pop = 1'b1;
        @(negedge clk);
        rd_pop = 1'b0;
    endtask

    task automatic wait_idle();
        int q = 0;
        while (q < 10) begin
            @(negedge clk);
            if (cs_n) q++; else q = 0;
        end
    endtask

    task automatic do_reset();
        rst = 1'b1;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        exp_q.delete();
        @(negedge clk);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        int f0;
        do_reset();
        // R8 reset state, R1 idle level
        check("R8 sclk", sclk, 0);
        check("R1 cs_n idle", cs_n, 1);
        check("R8 tx_req", tx_req, 1);
        check("R8 rx_req", rx_req, 0);
        check("R8 irqs", {tx_irq, rx_irq}, 0);
        check("R8 err", err, 0);

        // R9 pop from empty receive FIFO
        @(negedge clk); rd_pop = 1'b1;
        @(negedge clk); rd_pop = 1'b0;
        check("R9 err after empty pop", err, 1);
        check("R9 rx level untouched", rx_req, 0);
        repeat (3) @(negedge clk);
        check("R9 err sticky", err, 1);
        do_reset();
        check("R9 err cleared by reset", err, 0);

        // R3/R4 full-duplex loopback, 8 bits, slave reply must be ignored
        slave_word = 16'h005A;
        set_ctrl(32'h0000_0704);
        send(16'h00A5);
        send(16'h003C);
        send(16'h00F0);
        wait_idle();
        pop_check(16'h00A5, "R3 loopback word 0");
        pop_check(16'h003C, "R3 loopback word 1");
        pop_check(16'h00F0, "R10 loopback word 2");

        // R1/R2 external, resting high, 12 bits
        slave_word = 16'h0ABC;
        set_ctrl(32'h0000_0B08);
        check("R1 sclk rests high", sclk, 1);
        send(16'h0123);
        send(16'h0FED);
        wait_idle();
        check("R1 sclk high after frames", sclk, 1);
        pop_check(16'h0ABC, "R2 external rx 0");
        pop_check(16'h0ABC, "R2 external rx 1");

        // R5 half-duplex with loopback bit set: reply comes from miso
        slave_word = 16'h00C3;
        set_ctrl(32'h0000_0714);
        send(16'h0096);
        wait_idle();
        pop_check(16'h00C3, "R5 half-duplex reply");

        // R2 length field below 3 gives 4 bits
        set_ctrl(32'h0000_0004);
        send(16'h1237);
        send(16'h000A);
        wait_idle();
        pop_check(16'h0007, "R2 four-bit frame 0");
        pop_check(16'h000A, "R2 four-bit frame 1");

        // R6/R7 thresholds and masking: tx thr 1, rx thr 2 (needs 3), tx enable only
        set_ctrl(32'h0102_0706);
        send(16'h0011);
        send(16'h0022);
        send(16'h0033);
        repeat (6) @(negedge clk);
        check("R6 tx_req above threshold", tx_req, 0);
        check("R7 tx_irq follows req", tx_irq, 0);
        wait_idle();
        check("R6 tx_req drained", tx_req, 1);
        check("R7 tx_irq enabled", tx_irq, 1);
        check("R6 rx_req at three", rx_req, 1);
        check("R7 rx_irq masked", rx_irq, 0);
        set_ctrl(32'h0102_0707);
        check("R7 rx_irq enabled", rx_irq, 1);
        set_ctrl(32'h0102_0705);
        check("R7 tx_irq masked", tx_irq, 0);
        check("R7 tx_req unchanged by mask", tx_req, 1);
        pop_check(16'h0011, "R10 threshold word 0");
        check("R6 rx_req below threshold", rx_req, 0);
        check("R7 rx_irq follows req", rx_irq, 0);
        pop_check(16'h0022, "R10 threshold word 1");
        pop_check(16'h0033, "R10 threshold word 2");

        // R9 overflow: 18 back-to-back pushes, the last one is dropped
        set_ctrl(32'h0000_0304);
        f0 = frames_seen;
        for (int i = 0; i < 18; i++) begin
            @(negedge clk);
            wr_en = 1'b1; wr_addr = 2'd1; wr_data = i;
            if (i < 17) exp_q.push_back(16'(i & 15));
        end
        @(negedge clk);
        wr_en = 1'b0;
        check("R9 err on full push", err, 1);
        wait_idle();
        check("R9 frames sent", frames_seen - f0, 17);
        check("R9 scoreboard drained", exp_q.size(), 0);
        for (int i = 0; i < 16; i++)
            pop_check(16'(i), "R9 stored word");
        check("R9 extra rx word dropped", rx_req, 0);
        check("R9 err still set", err, 1);

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule